// File: doc/BRIEF.md
# Configurable General-Purpose I/O Bank

This block is a bank of general-purpose I/O ports for a small 8-bit controller. Software reaches it over a plain register bus with an address, write data, a write strobe, a read strobe and read data. The bank has three bidirectional ports: a wide port L, a narrow port C, and a wide port G whose two top pins can only be inputs. It also has an output-only port D and an input-only port I.

Each bidirectional pin takes its mode from two stored bits: a direction bit in the port's configuration register and a value bit in its data register. From that pair the bank drives three per-pin signals to the pad ring: an output enable, an output value and a weak pull-up enable. Every bidirectional port has three addresses: its data register, its configuration register, and a read-only view of its pad levels. Pad levels pass through a two-flop synchronizer before they can be read.

Any write to the port G data register also raises a one-cycle halt request for the clock and power logic elsewhere on the chip.

Top module: `gpio_bank`

## Requirements
- R1: For each pin of L, C and G, the output enable equals the configuration bit, the output value equals configuration AND data, and the pull-up enable equals NOT configuration AND data. So cfg=0/dat=0 is high-impedance, cfg=0/dat=1 is a pulled-up input, cfg=1/dat=0 drives low and cfg=1/dat=1 drives high.
- R2: The register map is: L data 0x0, L config 0x1, L pins 0x2; C data 0x4, C config 0x5, C pins 0x6; G data 0x8, G config 0x9, G pins 0xA; D data 0xC; I pins 0xD. A read of a data or config address returns the value last written there.
- R3: Port G bits 6 and 7 are input-only. Their configuration bits ignore writes, always read back as 0, and their output enables stay 0.
- R4: A write to the G data address (0x8) drives halt_req high for exactly the one cycle after the write cycle, whatever value bit 7 carries. Writes to any other address never raise it.
- R5: Reads of the C data, config and pin addresses return 0 in bits 7 to 4.
- R6: d_out is 0xFF while rst_n is low, and after reset it follows the last value written to address 0xC.
- R7: A read of address 0xD returns the synchronized level of the port I pads.
- R8: Reset clears every data and configuration register of L, C and G, so all their output enables, output values and pull-up enables are 0.
- R9: A pin read returns the pad level as it stood two rising clock edges earlier. A pad change is not visible after one edge and is visible after two.
- R10: Reads of unmapped addresses (0x3, 0x7, 0xB, 0xE, 0xF) return 0x00. Writes to the pin addresses and to unmapped addresses change no register and no output.
- R11: rd_data is 0x00 whenever rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, combinational from addr and rd_en |
| l_pad_in | input | 8 | Port L pad levels |
| l_oe | output | 8 | Port L output enables |
| l_out | output | 8 | Port L output values |
| l_pu | output | 8 | Port L weak pull-up enables |
| c_pad_in | input | 4 | Port C pad levels |
| c_oe | output | 4 | Port C output enables |
| c_out | output | 4 | Port C output values |
| c_pu | output | 4 | Port C weak pull-up enables |
| g_pad_in | input | 8 | Port G pad levels |
| g_oe | output | 8 | Port G output enables |
| g_out | output | 8 | Port G output values |
| g_pu | output | 8 | Port G weak pull-up enables |
| d_out | output | 8 | Port D output levels |
| i_pad_in | input | 8 | Port I pad levels |
| halt_req | output | 1 | One-cycle halt request |

## Verification
On every cycle, the assertions check these behaviours: a configuration write shows up on the port L output enables one cycle later; the input-only G pins never enable their drivers and never read back a configuration one; halt_req follows a G data write and no other access; the narrow port and unmapped addresses read zeros in the right bits; reads are silent while the strobe is low; and a port L pin read matches the pad two cycles earlier. Some behaviours only the bench scenarios can show. These are the value of port D while reset is held, the clearing done by a reset in the middle of a run, writes to read-only addresses leaving every register untouched, and the exact edge at which a pad change becomes visible.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   localparam int unsigned GB_AW = 4;
   localparam int unsigned GB_DW = 8;

   typedef logic [GB_AW-1:0] gb_addr_t;
   typedef logic [GB_DW-1:0] gb_byte_t;

   // register map; the pin-view addresses are read-only
   localparam gb_addr_t A_L_DAT = 4'h0;
   localparam gb_addr_t A_L_CFG = 4'h1;
   localparam gb_addr_t A_L_PIN = 4'h2;
   localparam gb_addr_t A_C_DAT = 4'h4;
   localparam gb_addr_t A_C_CFG = 4'h5;
   localparam gb_addr_t A_C_PIN = 4'h6;
   localparam gb_addr_t A_G_DAT = 4'h8;
   localparam gb_addr_t A_G_CFG = 4'h9;
   localparam gb_addr_t A_G_PIN = 4'hA;
   localparam gb_addr_t A_D_DAT = 4'hC;
   localparam gb_addr_t A_I_PIN = 4'hD;

   typedef struct packed {
      logic oe;
      logic val;
      logic pu;
   } pin_drv_t;

   // direction bit and value bit select one of four pin modes
   function automatic pin_drv_t decode_mode(input logic cfg, input logic dat);
      pin_drv_t d;
      d.oe  = cfg;
      d.val = cfg & dat;
      d.pu  = ~cfg & dat;
      return d;
   endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_bank_pkg::*;
#(
   parameter int           W       = 8,
   parameter logic [W-1:0] IN_ONLY = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         dat_we,
   input  logic         cfg_we,
   input  logic [W-1:0] wd,
   output logic [W-1:0] dat_q,
   output logic [W-1:0] cfg_q,
   output logic [W-1:0] oe,
   output logic [W-1:0] dout,
   output logic [W-1:0] pu
);

   generate
      if (W < 1 || W > GB_DW) begin : g_bad_w
         $error("gpio_port: W must lie in 1..%0d", GB_DW);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dat_q <= '0;
      else if (dat_we) dat_q <= wd;
   end

   generate
      for (genvar b = 0; b < W; b++) begin : g_bit
         pin_drv_t drv;
         if (IN_ONLY[b]) begin : g_in_only
            assign cfg_q[b] = 1'b0;
         end else begin : g_bidir
            logic cfg_r;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)      cfg_r <= 1'b0;
               else if (cfg_we) cfg_r <= wd[b];
            end
            assign cfg_q[b] = cfg_r;
         end
         assign drv     = decode_mode(cfg_q[b], dat_q[b]);
         assign oe[b]   = drv.oe;
         assign dout[b] = drv.val;
         assign pu[b]   = drv.pu;
      end
   endgenerate

endmodule

// File: rtl/gpio_outreg.sv
module gpio_outreg #(
   parameter int           W   = 8,
   parameter logic [W-1:0] RST = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wd,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST;
      else if (we) q <= wd;
   end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
   import gpio_bank_pkg::*;
#(
   parameter int               L_W         = 8,
   parameter int               C_W         = 4,
   parameter int               G_W         = 8,
   parameter logic [G_W-1:0]   G_IN_ONLY   = 8'hC0,
   parameter logic [GB_DW-1:0] D_RST       = 8'hFF,
   parameter int               SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [GB_AW-1:0] addr,
   input  logic             wr_en,
   input  logic [GB_DW-1:0] wr_data,
   input  logic             rd_en,
   output logic [GB_DW-1:0] rd_data,
   input  logic [L_W-1:0]   l_pad_in,
   output logic [L_W-1:0]   l_oe,
   output logic [L_W-1:0]   l_out,
   output logic [L_W-1:0]   l_pu,
   input  logic [C_W-1:0]   c_pad_in,
   output logic [C_W-1:0]   c_oe,
   output logic [C_W-1:0]   c_out,
   output logic [C_W-1:0]   c_pu,
   input  logic [G_W-1:0]   g_pad_in,
   output logic [G_W-1:0]   g_oe,
   output logic [G_W-1:0]   g_out,
   output logic [G_W-1:0]   g_pu,
   output logic [GB_DW-1:0] d_out,
   input  logic [GB_DW-1:0] i_pad_in,
   output logic             halt_req
);

   generate
      if (L_W < 1 || L_W > GB_DW) begin : g_bad_lw
         $error("gpio_bank: L_W out of range");
      end
      if (C_W < 1 || C_W > GB_DW) begin : g_bad_cw
         $error("gpio_bank: C_W out of range");
      end
      if (G_W < 1 || G_W > GB_DW) begin : g_bad_gw
         $error("gpio_bank: G_W out of range");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_bank: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // write decode
   logic we_l_dat, we_l_cfg, we_c_dat, we_c_cfg, we_g_dat, we_g_cfg, we_d;

   assign we_l_dat = wr_en && (addr == A_L_DAT);
   assign we_l_cfg = wr_en && (addr == A_L_CFG);
   assign we_c_dat = wr_en && (addr == A_C_DAT);
   assign we_c_cfg = wr_en && (addr == A_C_CFG);
   assign we_g_dat = wr_en && (addr == A_G_DAT);
   assign we_g_cfg = wr_en && (addr == A_G_CFG);
   assign we_d     = wr_en && (addr == A_D_DAT);

   // bidirectional ports
   logic [L_W-1:0] l_dat_q, l_cfg_q, l_pin_q;
   logic [C_W-1:0] c_dat_q, c_cfg_q, c_pin_q;
   logic [G_W-1:0] g_dat_q, g_cfg_q, g_pin_q;
   logic [GB_DW-1:0] i_pin_q;

   gpio_port #(.W(L_W), .IN_ONLY('0)) u_port_l (
      .clk(clk), .rst_n(rst_n), .dat_we(we_l_dat), .cfg_we(we_l_cfg),
      .wd(wr_data[L_W-1:0]), .dat_q(l_dat_q), .cfg_q(l_cfg_q),
      .oe(l_oe), .dout(l_out), .pu(l_pu)
   );

   gpio_port #(.W(C_W), .IN_ONLY('0)) u_port_c (
      .clk(clk), .rst_n(rst_n), .dat_we(we_c_dat), .cfg_we(we_c_cfg),
      .wd(wr_data[C_W-1:0]), .dat_q(c_dat_q), .cfg_q(c_cfg_q),
      .oe(c_oe), .dout(c_out), .pu(c_pu)
   );

   gpio_port #(.W(G_W), .IN_ONLY(G_IN_ONLY)) u_port_g (
      .clk(clk), .rst_n(rst_n), .dat_we(we_g_dat), .cfg_we(we_g_cfg),
      .wd(wr_data[G_W-1:0]), .dat_q(g_dat_q), .cfg_q(g_cfg_q),
      .oe(g_oe), .dout(g_out), .pu(g_pu)
   );

   gpio_outreg #(.W(GB_DW), .RST(D_RST)) u_port_d (
      .clk(clk), .rst_n(rst_n), .we(we_d), .wd(wr_data), .q(d_out)
   );

   // pad synchronizers
   gpio_sync #(.W(L_W), .STAGES(SYNC_STAGES)) u_sync_l (
      .clk(clk), .rst_n(rst_n), .d(l_pad_in), .q(l_pin_q)
   );
   gpio_sync #(.W(C_W), .STAGES(SYNC_STAGES)) u_sync_c (
      .clk(clk), .rst_n(rst_n), .d(c_pad_in), .q(c_pin_q)
   );
   gpio_sync #(.W(G_W), .STAGES(SYNC_STAGES)) u_sync_g (
      .clk(clk), .rst_n(rst_n), .d(g_pad_in), .q(g_pin_q)
   );
   gpio_sync #(.W(GB_DW), .STAGES(SYNC_STAGES)) u_sync_i (
      .clk(clk), .rst_n(rst_n), .d(i_pad_in), .q(i_pin_q)
   );

   // read mux; narrow ports are zero-extended
   logic [GB_DW-1:0] l_dat_x, l_cfg_x, l_pin_x;
   logic [GB_DW-1:0] c_dat_x, c_cfg_x, c_pin_x;
   logic [GB_DW-1:0] g_dat_x, g_cfg_x, g_pin_x;

   always_comb begin
      l_dat_x = '0;  l_dat_x[L_W-1:0] = l_dat_q;
      l_cfg_x = '0;  l_cfg_x[L_W-1:0] = l_cfg_q;
      l_pin_x = '0;  l_pin_x[L_W-1:0] = l_pin_q;
      c_dat_x = '0;  c_dat_x[C_W-1:0] = c_dat_q;
      c_cfg_x = '0;  c_cfg_x[C_W-1:0] = c_cfg_q;
      c_pin_x = '0;  c_pin_x[C_W-1:0] = c_pin_q;
      g_dat_x = '0;  g_dat_x[G_W-1:0] = g_dat_q;
      g_cfg_x = '0;  g_cfg_x[G_W-1:0] = g_cfg_q;
      g_pin_x = '0;  g_pin_x[G_W-1:0] = g_pin_q;
   end

   always_comb begin
      rd_data = '0;
      if (rd_en) begin
         case (addr)
            A_L_DAT: rd_data = l_dat_x;
            A_L_CFG: rd_data = l_cfg_x;
            A_L_PIN: rd_data = l_pin_x;
            A_C_DAT: rd_data = c_dat_x;
            A_C_CFG: rd_data = c_cfg_x;
            A_C_PIN: rd_data = c_pin_x;
            A_G_DAT: rd_data = g_dat_x;
            A_G_CFG: rd_data = g_cfg_x;
            A_G_PIN: rd_data = g_pin_x;
            A_D_DAT: rd_data = d_out;
            A_I_PIN: rd_data = i_pin_q;
            default: rd_data = '0;
         endcase
      end
   end

   // halt request: one pulse per accepted G data write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) halt_req <= 1'b0;
      else        halt_req <= we_g_dat;
   end

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
   import gpio_bank_pkg::*;
#(
   parameter int             L_W         = 8,
   parameter int             C_W         = 4,
   parameter int             G_W         = 8,
   parameter logic [G_W-1:0] G_IN_ONLY   = 8'hC0,
   parameter int             SYNC_STAGES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [GB_AW-1:0] addr,
   input logic             wr_en,
   input logic [GB_DW-1:0] wr_data,
   input logic             rd_en,
   input logic [GB_DW-1:0] rd_data,
   input logic [L_W-1:0]   l_pad_in,
   input logic [L_W-1:0]   l_oe,
   input logic [G_W-1:0]   g_oe,
   input logic             halt_req
);

   logic [1:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              since_rst <= 2'd0;
      else if (since_rst != 2) since_rst <= since_rst + 2'd1;
   end

   // R1: a config write reaches the output enables one cycle later
   p_cfg_to_oe_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_L_CFG) |=> (l_oe == $past(wr_data[L_W-1:0])));

   // R3: input-only G pins never drive
   p_g_in_only_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((g_oe & G_IN_ONLY) == '0));

   // R3: input-only G config bits read as zero
   p_g_in_only_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == A_G_CFG) |-> ((rd_data[G_W-1:0] & G_IN_ONLY) == '0));

   // R4: G data write is followed by the halt pulse
   p_halt_after_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_G_DAT) |=> halt_req);

   // R4: halt pulse only after a G data write
   p_halt_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      halt_req |-> $past(wr_en && addr == A_G_DAT));

   // R5: narrow port reads zero above its width
   p_c_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (addr == A_C_DAT || addr == A_C_CFG || addr == A_C_PIN))
         |-> ((rd_data >> C_W) == '0));

   // R10: unmapped reads return zero
   p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (addr == 4'h3 || addr == 4'h7 || addr == 4'hB
                 || addr == 4'hE || addr == 4'hF)) |-> (rd_data == '0));

   // R11: no read strobe, no read data
   p_idle_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> (rd_data == '0));

   // R9: pin view lags the pad by two edges (default depth only)
   generate
      if (SYNC_STAGES == 2) begin : g_lag
         p_pin_lag_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst == 2'd2 && rd_en && addr == A_L_PIN)
               |-> (rd_data[L_W-1:0] == $past(l_pad_in, 2)));
      end
   endgenerate

endmodule

bind gpio_bank gpio_bank_chk #(
   .L_W(L_W), .C_W(C_W), .G_W(G_W), .G_IN_ONLY(G_IN_ONLY), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
   .rd_en(rd_en), .rd_data(rd_data), .l_pad_in(l_pad_in), .l_oe(l_oe),
   .g_oe(g_oe), .halt_req(halt_req)
);

// File: tb/gpio_bank_test.sv
`timescale 1ns/1ps
module gpio_bank_test;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [3:0] addr;
   logic       wr_en, rd_en;
   logic [7:0] wr_data, rd_data;
   logic [7:0] l_pad_in, l_oe, l_out, l_pu;
   logic [3:0] c_pad_in, c_oe, c_out, c_pu;
   logic [7:0] g_pad_in, g_oe, g_out, g_pu;
   logic [7:0] d_out, i_pad_in;
   logic       halt_req;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;

   // bench model of the register state
   logic [7:0] m_ld, m_lc, m_gd, m_gc, m_d;
   logic [3:0] m_cd, m_cc;

   always #4 clk = ~clk;

   gpio_bank uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data),
      .l_pad_in(l_pad_in), .l_oe(l_oe), .l_out(l_out), .l_pu(l_pu),
      .c_pad_in(c_pad_in), .c_oe(c_oe), .c_out(c_out), .c_pu(c_pu),
      .g_pad_in(g_pad_in), .g_oe(g_oe), .g_out(g_out), .g_pu(g_pu),
      .d_out(d_out), .i_pad_in(i_pad_in), .halt_req(halt_req)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_read(input logic [3:0] a);
      case (a)
         4'h0: return m_ld;
         4'h1: return m_lc;
         4'h2: return l_pad_in;
         4'h4: return {4'h0, m_cd};
         4'h5: return {4'h0, m_cc};
         4'h6: return {4'h0, c_pad_in};
         4'h8: return m_gd;
         4'h9: return m_gc;
         4'hA: return g_pad_in;
         4'hC: return m_d;
         4'hD: return i_pad_in;
         default: return 8'h00;
      endcase
   endfunction

   task automatic model_reset();
      m_ld = 0; m_lc = 0; m_cd = 0; m_cc = 0; m_gd = 0; m_gc = 0; m_d = 8'hFF;
   endtask

   task automatic model_write(input logic [3:0] a, input logic [7:0] d);
      case (a)
         4'h0: m_ld = d;
         4'h1: m_lc = d;
         4'h4: m_cd = d[3:0];
         4'h5: m_cc = d[3:0];
         4'h8: m_gd = d;
         4'h9: m_gc = d & 8'h3F;
         4'hC: m_d  = d;
         default: ;
      endcase
   endtask

   task automatic bwrite(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      model_write(a, d);
   endtask

   task automatic peek(input logic [3:0] a, output logic [7:0] v);
      addr = a; rd_en = 1'b1;
      #1;
      v = rd_data;
      rd_en = 1'b0;
   endtask

   task automatic check_outputs(input string tag);
      chk({tag, " R1 l_oe"},  l_oe,  m_lc);
      chk({tag, " R1 l_out"}, l_out, m_lc & m_ld);
      chk({tag, " R1 l_pu"},  l_pu,  ~m_lc & m_ld);
      chk({tag, " R1 c_oe"},  {4'h0, c_oe},  {4'h0, m_cc});
      chk({tag, " R1 c_out"}, {4'h0, c_out}, {4'h0, m_cc & m_cd});
      chk({tag, " R1 c_pu"},  {4'h0, c_pu},  {4'h0, ~m_cc & m_cd});
      chk({tag, " R3 g_oe"},  g_oe,  m_gc);
      chk({tag, " R1 g_out"}, g_out, m_gc & m_gd);
      chk({tag, " R1 g_pu"},  g_pu,  ~m_gc & m_gd);
      chk({tag, " R6 d_out"}, d_out, m_d);
   endtask

   task automatic check_read(input string tag, input logic [3:0] a);
      logic [7:0] v;
      peek(a, v);
      chk($sformatf("%s read %h", tag, a), v, exp_read(a));
   endtask

   initial begin
      logic [7:0] v;
      logic [31:0] seed_val;
      seed_val = $urandom(32'd7321);
      rst_n = 1'b0; addr = 0; wr_en = 0; rd_en = 0; wr_data = 0;
      l_pad_in = 0; c_pad_in = 0; g_pad_in = 0; i_pad_in = 0;
      model_reset();
      repeat (3) @(negedge clk);
      chk("R6 d_out during reset", d_out, 8'hFF);
      rst_n = 1'b1;
      @(negedge clk);

      // R8 reset state
      check_outputs("R8 reset");
      chk("R8 halt after reset", {7'd0, halt_req}, 8'h00);
      for (int a = 0; a < 16; a++) check_read("R8 R2 R10", a[3:0]);

      // R1 all four modes on L and C
      bwrite(4'h1, 8'hF0);
      bwrite(4'h0, 8'hCC);
      bwrite(4'h5, 8'h0A);
      bwrite(4'h4, 8'h0C);
      check_outputs("R1 modes");
      check_read("R2 L data", 4'h0);
      check_read("R2 L cfg", 4'h1);

      // R3 input-only G pins
      bwrite(4'h9, 8'hFF);
      check_read("R3 G cfg", 4'h9);
      chk("R3 g_oe top bits", g_oe & 8'hC0, 8'h00);
      bwrite(4'h8, 8'hC3);
      chk("R4 halt after G write 0xC3", {7'd0, halt_req}, 8'h01);
      chk("R3 g_pu top pins pulled", g_pu & 8'hC0, 8'hC0);
      @(negedge clk);
      chk("R4 halt drops", {7'd0, halt_req}, 8'h00);

      // R4 halt with bit 7 clear, and no halt for other writes
      bwrite(4'h8, 8'h00);
      chk("R4 halt bit7=0", {7'd0, halt_req}, 8'h01);
      bwrite(4'h0, 8'h80);
      chk("R4 no halt for L write", {7'd0, halt_req}, 8'h00);
      bwrite(4'h9, 8'h80);
      chk("R4 no halt for G cfg write", {7'd0, halt_req}, 8'h00);

      // R5 narrow port
      bwrite(4'h4, 8'hFF);
      bwrite(4'h5, 8'hF5);
      c_pad_in = 4'hF;
      @(negedge clk); @(negedge clk);
      check_read("R5 C data", 4'h4);
      check_read("R5 C cfg", 4'h5);
      check_read("R5 C pins", 4'h6);

      // R6 D port
      bwrite(4'hC, 8'h5A);
      chk("R6 d_out written", d_out, 8'h5A);
      check_read("R6 D readback", 4'hC);

      // R9 and R7 pad lag
      l_pad_in = 8'h00; i_pad_in = 8'h00;
      repeat (3) @(negedge clk);
      l_pad_in = 8'hA5; i_pad_in = 8'h3C;
      @(negedge clk);
      peek(4'h2, v); chk("R9 L pins after one edge", v, 8'h00);
      peek(4'hD, v); chk("R7 I pins after one edge", v, 8'h00);
      @(negedge clk);
      peek(4'h2, v); chk("R9 L pins after two edges", v, 8'hA5);
      peek(4'hD, v); chk("R7 I pins after two edges", v, 8'h3C);

      // R10 writes to read-only and unmapped addresses
      bwrite(4'h2, 8'h11);
      bwrite(4'hA, 8'h22);
      bwrite(4'h6, 8'h33);
      bwrite(4'hD, 8'h44);
      bwrite(4'hF, 8'h55);
      bwrite(4'h3, 8'h66);
      check_outputs("R10 ignored writes");
      for (int a = 0; a < 16; a++) check_read("R10 after ignored writes", a[3:0]);

      // R11 no strobe
      addr = 4'h0; rd_en = 1'b0; #1;
      chk("R11 rd_data idle", rd_data, 8'h00);

      // R6 R8 reset mid-run
      @(negedge clk);
      rst_n = 1'b0; #1;
      chk("R6 d_out on mid reset", d_out, 8'hFF);
      chk("R8 l_oe on mid reset", l_oe, 8'h00);
      chk("R8 l_pu on mid reset", l_pu, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      model_reset();
      repeat (2) @(negedge clk);
      check_outputs("R8 after mid reset");

      // constrained random phase
      for (int it = 0; it < 400; it++) begin
         logic [3:0] a;
         logic [7:0] d;
         l_pad_in = 8'($urandom);
         c_pad_in = 4'($urandom);
         g_pad_in = 8'($urandom);
         i_pad_in = 8'($urandom);
         a = 4'($urandom);
         d = 8'($urandom);
         bwrite(a, d);
         chk($sformatf("R4 halt after write to %h", a), {7'd0, halt_req},
             {7'd0, (a == 4'h8)});
         check_outputs("R1 random");
         check_read("R2 random", 4'($urandom));
         @(negedge clk);
         chk("R4 halt single cycle", {7'd0, halt_req}, 8'h00);
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog R1..: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule